// File: doc/BRIEF.md
# IrDA Interrupt Status Controller

This block gathers single-cycle event pulses from an infrared link controller into two interrupt banks and drives one interrupt line toward the processor. One bank serves the slow asynchronous (SIR) link mode. The other bank is shared by the medium and fast (MIR/FIR) link modes. Each bank has a sticky status register, a mask register and a write-one-to-clear register. A transfer-mode register holds the 2-bit link mode field and three group masks. The group masks add a second gating level above the per-bank masks. All registers sit on a plain 16-bit register bus with a word address and a single-cycle write strobe. Reads are combinational.

Both banks use the same five bit positions. Two of those positions change meaning with the link mode:
- Bit 9 is a receive timeout in SIR and an abort detection in MIR/FIR.
- Bit 8 is a framing error in SIR and a CRC error in MIR/FIR.

The other three bit positions mean the same thing in every mode:
- Bit 15 flags the end of a received frame.
- Bit 11 flags an overflow of the transfer area.
- Bit 7 flags the end of a transmitted frame.

Software opens the group of the bank that matches the current mode. Events for the other bank are still recorded, but they stay silent.

Top module: `irda_irq_ctl`

## Requirements
- R1: After reset, both status registers read 0x0000, both mask registers read 0x8B80, the transfer-mode register reads 0x0111 and irq is low.
- R2: Each bank has a 5-bit event input. Event index 0, 1, 2, 3 and 4 sets status bit 7, 8, 9, 11 and 15 of its bank one clock later. A set bit stays set until it is cleared.
- R3: Writing to a bank's clear register clears exactly the status bits written as 1. Bits written as 0 are left unchanged.
- R4: When an event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R5: Status registers are read-only. A write to a status address leaves its contents unchanged.
- R6: Only mask bits 15, 11, 9, 8 and 7 are writable. Every other mask bit reads 0. A mask bit of 1 blocks its status bit.
- R7: irq is high exactly when a bank has a status bit whose mask bit is 0 and that bank's group mask is 0. The group mask is transfer-mode bit 0 for the SIR bank and bit 4 for the MIR/FIR bank.
- R8: The transfer-mode register stores bits 15:14 (the link mode: SIR=00, FIR=10, MIR=11) and bits 8, 4 and 0 (the group masks, where bit 8 is the FIFO receive mask). All its other bits read 0.
- R9: Events for a bank whose group is masked are still recorded in its status register, but they do not raise irq.
- R10: Clear registers read as 0x0000.
- Register word addresses: 0 is transfer mode. 1, 2 and 3 are the SIR status, mask and clear registers. 4, 5 and 6 are the MIR/FIR status, mask and clear registers. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from bus_addr) |
| sir_evt | input | 5 | SIR-bank event pulses, index 0..4 mapped to bits 7, 8, 9, 11, 15 |
| mf_evt | input | 5 | MIR/FIR-bank event pulses, same mapping |
| irq | output | 1 | Interrupt request |

## Verification
The main gating function is tried with combinations of the event bank, the per-bank mask and the group mask. These combinations separate the pass case from a block at the bank level and from a block at the group level. Each case is run in both banks, so the test would catch swapped group bits or swapped bank addresses. Status readback after each pattern shows that recording does not depend on masking. Single cases then cover a set and a clear in the same cycle, a partial clear, a write to a status address, and writes of all ones to the mask and mode registers, which expose the bits that are not implemented.

// File: rtl/irda_irq_pkg.sv
package irda_irq_pkg;
   localparam int REG_W  = 16;
   localparam int NUM_EV = 5;
   localparam logic [REG_W-1:0] EV_IMPL   = 16'h8B80;
   localparam logic [REG_W-1:0] MODE_IMPL = 16'hC111;
   localparam logic [REG_W-1:0] MODE_RST  = 16'h0111;
   localparam int GM_SIR  = 0;
   localparam int GM_MF   = 4;
   localparam int GM_FIFO = 8;
   localparam int A_MODE  = 0;
   localparam int A_BANK0 = 1;   // status, mask, clear at base+0/1/2
   localparam int BANK_SPAN = 3;

   typedef enum logic [1:0] {
      LM_SIR  = 2'b00,
      LM_NONE = 2'b01,
      LM_FIR  = 2'b10,
      LM_MIR  = 2'b11
   } link_mode_e;

   // event index -> status bit position
   function automatic int ev_pos(input int idx);
      case (idx)
         0:       return 7;
         1:       return 8;
         2:       return 9;
         3:       return 11;
         default: return 15;
      endcase
   endfunction
endpackage

// File: rtl/irda_irq_mode.sv
module irda_irq_mode
   import irda_irq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mode_q
);
   if (DATA_W != REG_W) begin : g_bad_w
      $error("irda_irq_mode: DATA_W must be %0d", REG_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode_q <= MODE_RST;
      else if (we) mode_q <= wdata & MODE_IMPL;
   end
endmodule

// File: rtl/irda_irq_bank.sv
module irda_irq_bank
   import irda_irq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NEV      = 5,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEV-1:0]    evt,
   input  logic              mask_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stat,
   output logic [DATA_W-1:0] mask,
   output logic              pend
);
   if (DATA_W != REG_W) begin : g_bad_w
      $error("irda_irq_bank: DATA_W must be %0d", REG_W);
   end
   if (NEV != NUM_EV) begin : g_bad_n
      $error("irda_irq_bank: NEV must be %0d", NUM_EV);
   end

   logic [DATA_W-1:0] set_v, clr_v, stat_nxt;

   always_comb begin
      set_v = '0;
      for (int i = 0; i < NEV; i++) set_v[ev_pos(i)] = evt[i];
   end

   assign clr_v = clr_we ? wdata : '0;

   if (SET_WINS) begin : g_set_wins
      assign stat_nxt = ((stat & ~clr_v) | set_v) & EV_IMPL;
   end else begin : g_clr_wins
      assign stat_nxt = (stat | set_v) & ~clr_v & EV_IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         mask <= EV_IMPL;
      end else begin
         stat <= stat_nxt;
         if (mask_we) mask <= wdata & EV_IMPL;
      end
   end

   assign pend = |(stat & ~mask);
endmodule

// File: rtl/irda_irq_ctl.sv
module irda_irq_ctl
   import irda_irq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int NEV      = 5,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NEV-1:0]    sir_evt,
   input  logic [NEV-1:0]    mf_evt,
   output logic              irq
);
   localparam int NBANK = 2;
   localparam int LAST_A = A_BANK0 + NBANK*BANK_SPAN - 1;

   if (ADDR_W < $clog2(LAST_A + 1)) begin : g_bad_a
      $error("irda_irq_ctl: ADDR_W too small for %0d registers", LAST_A + 1);
   end

   logic [DATA_W-1:0] mode_q;
   logic [DATA_W-1:0] bank_stat [NBANK];
   logic [DATA_W-1:0] bank_mask [NBANK];
   logic [NEV-1:0]    bank_evt  [NBANK];
   logic [NBANK-1:0]  bank_pend;
   logic [NBANK-1:0]  grp_mask;

   assign bank_evt[0] = sir_evt;
   assign bank_evt[1] = mf_evt;
   assign grp_mask    = {mode_q[GM_MF], mode_q[GM_SIR]};

   irda_irq_mode #(.DATA_W(DATA_W)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_wr && (bus_addr == ADDR_W'(A_MODE))),
      .wdata  (bus_wdata),
      .mode_q (mode_q)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int BASE = A_BANK0 + b*BANK_SPAN;
      irda_irq_bank #(.DATA_W(DATA_W), .NEV(NEV), .SET_WINS(SET_WINS)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (bank_evt[b]),
         .mask_we (bus_wr && (bus_addr == ADDR_W'(BASE + 1))),
         .clr_we  (bus_wr && (bus_addr == ADDR_W'(BASE + 2))),
         .wdata   (bus_wdata),
         .stat    (bank_stat[b]),
         .mask    (bank_mask[b]),
         .pend    (bank_pend[b])
      );
   end

   assign irq = |(bank_pend & ~grp_mask);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_MODE)) bus_rdata = mode_q;
      for (int b = 0; b < NBANK; b++) begin
         if (bus_addr == ADDR_W'(A_BANK0 + b*BANK_SPAN))     bus_rdata = bank_stat[b];
         if (bus_addr == ADDR_W'(A_BANK0 + b*BANK_SPAN + 1)) bus_rdata = bank_mask[b];
      end
   end
endmodule

// File: rtl/irda_irq_ctl_chk.sv
module irda_irq_ctl_chk
   import irda_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [4:0]        sir_evt,
   input logic              irq,
   input logic [DATA_W-1:0] sir_stat,
   input logic [DATA_W-1:0] mf_stat,
   input logic [DATA_W-1:0] sir_mask,
   input logic [DATA_W-1:0] mode_q
);
   logic sir_clr;
   assign sir_clr = bus_wr && (bus_addr == ADDR_W'(3));

   // R2: without a clear write, set bits stay set
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sir_clr |=> ((sir_stat & $past(sir_stat)) == $past(sir_stat)));

   // R3: a clear with no events removes the written bits
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sir_clr && sir_evt == '0) |=> ((sir_stat & $past(bus_wdata)) == '0));

   // R4: an event on index 0 always lands in bit 7, even under a clear
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sir_evt[0] |=> sir_stat[7]);

   // R6: unimplemented mask bits stay zero
   p_mask_impl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sir_mask & ~EV_IMPL) == '0);

   // R7: both groups closed means no interrupt
   p_grp_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[GM_SIR] && mode_q[GM_MF]) |-> !irq);

   // R7: nothing recorded means no interrupt
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sir_stat == '0 && mf_stat == '0) |-> !irq);
endmodule

bind irda_irq_ctl irda_irq_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .sir_evt   (sir_evt),
   .irq       (irq),
   .sir_stat  (bank_stat[0]),
   .mf_stat   (bank_stat[1]),
   .sir_mask  (bank_mask[0]),
   .mode_q    (mode_q)
);

// File: tb/irda_irq_ctl_test.sv
module irda_irq_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [4:0]  sir_evt = '0;
   logic [4:0]  mf_evt = '0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irda_irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sir_evt(sir_evt), .mf_evt(mf_evt), .irq(irq)
   );

   // {sir_evt, mf_evt, mode, sir_mask, mf_mask, exp_irq}
   typedef struct packed {
      logic [4:0]  sev;
      logic [4:0]  mev;
      logic [15:0] mode;
      logic [15:0] smsk;
      logic [15:0] mmsk;
      logic        irq;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{5'h01, 5'h00, 16'h0110, 16'h0000, 16'hFFFF, 1'b1},
      '{5'h01, 5'h00, 16'h0110, 16'h0080, 16'hFFFF, 1'b0},
      '{5'h01, 5'h00, 16'h0111, 16'h0000, 16'h0000, 1'b0},
      '{5'h00, 5'h10, 16'hC101, 16'hFFFF, 16'h0000, 1'b1},
      '{5'h00, 5'h10, 16'hC101, 16'h0000, 16'h8000, 1'b0},
      '{5'h00, 5'h04, 16'h8110, 16'h0000, 16'h0000, 1'b0},
      '{5'h08, 5'h00, 16'h0100, 16'h0000, 16'h0800, 1'b1},
      '{5'h00, 5'h08, 16'h0100, 16'h0000, 16'h0800, 1'b0}
   };

   function automatic logic [15:0] ev_map(input logic [4:0] e);
      return {e[4], 3'b000, e[3], 1'b0, e[2], e[1], e[0], 7'b0};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = 4'(a);
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input logic [4:0] s, input logic [4:0] m);
      @(negedge clk);
      sir_evt = s; mf_evt = m;
      @(negedge clk);
      sir_evt = '0; mf_evt = '0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, d); check("R1 mode", d, 16'h0111);
      rd(1, d); check("R1 sir status", d, 16'h0000);
      rd(2, d); check("R1 sir mask", d, 16'h8B80);
      rd(4, d); check("R1 mf status", d, 16'h0000);
      rd(5, d); check("R1 mf mask", d, 16'h8B80);
      check("R1 irq", {15'b0, irq}, 16'h0000);

      // table walk: R2 R7 R9
      foreach (VECS[k]) begin
         wr(0, 16'h0111);
         wr(3, 16'hFFFF); wr(6, 16'hFFFF);
         wr(2, VECS[k].smsk); wr(5, VECS[k].mmsk);
         wr(0, VECS[k].mode);
         pulse(VECS[k].sev, VECS[k].mev);
         #1;
         check($sformatf("R7 irq vec%0d", k), {15'b0, irq}, {15'b0, VECS[k].irq});
         rd(1, d); check($sformatf("R2 sir status vec%0d", k), d, ev_map(VECS[k].sev));
         rd(4, d); check($sformatf("R9 mf status vec%0d", k), d, ev_map(VECS[k].mev));
      end

      // R2 all events, sticky over idle cycles
      wr(0, 16'h0111); wr(3, 16'hFFFF); wr(6, 16'hFFFF);
      pulse(5'h1F, 5'h00);
      repeat (4) @(negedge clk);
      rd(1, d); check("R2 all bits sticky", d, 16'h8B80);

      // R3 partial clear
      wr(3, 16'h0880);
      rd(1, d); check("R3 partial clear", d, 16'h8300);

      // R5 status write ignored
      wr(1, 16'h0000);
      rd(1, d); check("R5 status read-only", d, 16'h8300);

      // R10 clear register reads zero
      rd(3, d); check("R10 clear reads zero", d, 16'h0000);

      // R4 set and clear of bit 7 in the same cycle
      @(negedge clk);
      bus_addr = 4'd3; bus_wdata = 16'h0080; bus_wr = 1'b1; sir_evt = 5'h01;
      @(negedge clk);
      bus_wr = 1'b0; sir_evt = '0;
      rd(1, d); check("R4 set wins", d, 16'h8380);

      // R6 mask bit implementation
      wr(5, 16'hFFFF);
      rd(5, d); check("R6 mask implemented bits", d, 16'h8B80);
      wr(5, 16'h7477);
      rd(5, d); check("R6 mask unimplemented zero", d, 16'h0000);

      // R8 mode register fields
      wr(0, 16'hFFFF);
      rd(0, d); check("R8 mode all ones", d, 16'hC111);
      wr(0, 16'h8000);
      rd(0, d); check("R8 mode FIR open", d, 16'h8000);

      // R7 group gating with SIR pending (bits 15,9,8,7 unmasked)
      wr(2, 16'h0000);
      wr(0, 16'h0011);
      #1 check("R7 both groups closed", {15'b0, irq}, 16'h0000);
      wr(0, 16'h0010);
      #1 check("R7 SIR group open", {15'b0, irq}, 16'h0001);
      wr(3, 16'hFFFF);
      #1 check("R3 clear drops irq", {15'b0, irq}, 16'h0000);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule